// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector with Lock Flag

This block compares two streams of edge events and reports which one arrives first. The events come from the dividers of a synthesizer loop: a divided reference and a divided oscillator. Both streams are sampled in a single system clock domain, and each event is a pulse one clock wide. Each stream sets its own sticky flag. The reference sets the up flag and the oscillator sets the down flag. Once both flags are set, both are cleared on the next clock. The time a flag is held alone is therefore the phase error, measured in clock cycles.

The error is reported in two forms:

- **Single-ended form.** This output has three states, modelled as a drive enable and a drive level. It drives high while only the up flag is set (the oscillator is lagging or slow). It drives low while only the down flag is set (the oscillator is leading or fast). It floats when the flags agree.
- **Double-ended form.** This is an active-low pair, one output per input, for external combination.

A registered lock flag is high while the flags agree. It drops for each cycle in which a one-sided correction is under way.

Top module: `pfd_tristate`

## Requirements
- R1: While `rst_n` is low at a clock edge, both flags are cleared, so `ref_err_n`=1, `vco_err_n`=1, `drv_en`=0, `drv_lvl`=0. The lock flag `lock_ok` is cleared to 0, and edges on the inputs are ignored.
- R2: A `ref_edge` pulse with the down flag clear makes `ref_err_n`=0 from the next cycle, with `vco_err_n`=1, `drv_en`=1 and `drv_lvl`=1. This holds until a `vco_edge` arrives.
- R3: A `vco_edge` pulse with the up flag clear makes `vco_err_n`=0 from the next cycle, with `ref_err_n`=1, `drv_en`=1 and `drv_lvl`=0. This holds until a `ref_edge` arrives.
- R4: For one edge on each input, d cycles apart, `drv_en` is high for exactly d cycles.
- R5: Edges on both inputs in the same cycle drive `ref_err_n` and `vco_err_n` low together for exactly one cycle, and `drv_en` stays 0.
- R6: The cycle after both flags are seen set, both are cleared. An edge that arrives in that clearing cycle sets its flag again, so no event is lost.
- R7: `lock_ok` is registered. It is 0 in the cycle after any cycle in which exactly one flag is set, and 1 in the cycle after any cycle in which the flags agree.
- R8: Further edges on an input whose flag is already set have no effect. The error lasts from the first of them until the opposite edge.
- R9: `drv_lvl` is 0 whenever `drv_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_edge | input | 1 | One-cycle pulse per divided reference edge |
| vco_edge | input | 1 | One-cycle pulse per divided oscillator edge |
| drv_en | output | 1 | Single-ended error drive enable (0 = high impedance) |
| drv_lvl | output | 1 | Single-ended error level while enabled |
| ref_err_n | output | 1 | Active-low reference-side error (up flag) |
| vco_err_n | output | 1 | Active-low oscillator-side error (down flag) |
| lock_ok | output | 1 | Registered lock flag, high when no correction is under way |

## Verification
A flag stuck set, or one that fails to clear, shows at the ports on the very next cycle. It appears as an extended low on one of the active-low pair, and `drv_en` stays up where the expected value floats. One cycle after that, `lock_ok` drops. A broken clear path is visible in the same way. It either stretches the coincident pulse past one cycle or loses an edge that lands in the clearing cycle, and a lost edge lengthens the next error pulse by the full interval between edges. Wrong polarity in the encoder appears at once as `drv_lvl` disagreeing with which member of the pair is low.

// File: rtl/pfd_pkg.sv
`timescale 1ns/1ps
// Shared types for the phase-frequency detector.
package pfd_pkg;
    // Number of compared edge streams (reference, oscillator).
    localparam int unsigned SIDES = 2;
    localparam int unsigned SIDE_REF = 0;
    localparam int unsigned SIDE_VCO = 1;

    // Drive state of the single-ended error output.
    typedef enum logic [1:0] {
        SE_FLOAT = 2'b00,
        SE_HIGH  = 2'b11,
        SE_LOW   = 2'b10
    } se_mode_e;
endpackage

// File: rtl/pfd_edge_flag.sv
`timescale 1ns/1ps
// Sticky edge flag for one input stream.
// Sets on an edge pulse and holds until the shared clear request.
// An edge arriving in the clearing cycle wins, so no event is dropped.
// Assumes edge pulses are synchronous to clk and one cycle wide.
module pfd_edge_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_in,
    input  logic clr_req,
    output logic flag_q
);
    // Flag register: reset, clear-with-priority-to-new-edge, or sticky set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (clr_req)
            flag_q <= edge_in;
        else
            flag_q <= flag_q | edge_in;
    end
endmodule

// File: rtl/pfd_error_encode.sv
`timescale 1ns/1ps
// Maps the up/down flag pair onto both error output forms.
// Single-ended output is driven only when exactly one flag is set.
// Inputs are register outputs, so the outputs here are glitch-free.
module pfd_error_encode
    import pfd_pkg::*;
(
    input  logic     up_q,
    input  logic     dn_q,
    output se_mode_e se_mode,
    output logic     ref_err_n,
    output logic     vco_err_n
);
    // Select single-ended drive state from the flag pair.
    always_comb begin
        unique case ({up_q, dn_q})
            2'b10:   se_mode = SE_HIGH;
            2'b01:   se_mode = SE_LOW;
            default: se_mode = SE_FLOAT;
        endcase
    end

    // Double-ended pair is the inverted flag state.
    always_comb begin
        ref_err_n = ~up_q;
        vco_err_n = ~dn_q;
    end
endmodule

// File: rtl/pfd_lock_flag.sv
`timescale 1ns/1ps
// Registered lock indicator.
// Goes low for each cycle after one in which the flags disagree.
// Assumes flag inputs are register outputs in the same clock domain.
module pfd_lock_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic up_q,
    input  logic dn_q,
    output logic lock_q
);
    // Lock register: deasserted in reset, else high when flags agree.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else
            lock_q <= ~(up_q ^ dn_q);
    end
endmodule

// File: rtl/pfd_tristate.sv
`timescale 1ns/1ps
// Phase-frequency detector top.
// Compares reference and oscillator edge pulses using two sticky flags,
// cleared together one cycle after both are set (one-cycle coincident
// pulse). Reports the error as a three-state single-ended output
// (enable + level), an active-low pair and a registered lock flag.
// Assumes both inputs are one-cycle pulses synchronous to clk.
module pfd_tristate
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_edge,
    input  logic vco_edge,
    output logic drv_en,
    output logic drv_lvl,
    output logic ref_err_n,
    output logic vco_err_n,
    output logic lock_ok
);
    logic [SIDES-1:0] edge_vec;
    logic [SIDES-1:0] flag_vec;
    logic             clr_req;
    se_mode_e         se_mode;

    // Gather inputs into a per-side vector.
    always_comb begin
        edge_vec[SIDE_REF] = ref_edge;
        edge_vec[SIDE_VCO] = vco_edge;
    end

    // Both flags seen set: clear them on the next edge.
    always_comb clr_req = &flag_vec;

    // One sticky flag per compared stream.
    for (genvar s = 0; s < SIDES; s++) begin : g_side
        pfd_edge_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .edge_in (edge_vec[s]),
            .clr_req (clr_req),
            .flag_q  (flag_vec[s])
        );
    end

    pfd_error_encode u_enc (
        .up_q      (flag_vec[SIDE_REF]),
        .dn_q      (flag_vec[SIDE_VCO]),
        .se_mode   (se_mode),
        .ref_err_n (ref_err_n),
        .vco_err_n (vco_err_n)
    );

    pfd_lock_flag u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .up_q   (flag_vec[SIDE_REF]),
        .dn_q   (flag_vec[SIDE_VCO]),
        .lock_q (lock_ok)
    );

    // Split the drive state into enable and level pins.
    always_comb begin
        drv_en  = se_mode[1];
        drv_lvl = se_mode[0];
    end
endmodule

// File: rtl/pfd_tristate_chk.sv
`timescale 1ns/1ps
// Assertion checker for pfd_tristate, attached by bind.
module pfd_tristate_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_edge,
    input logic vco_edge,
    input logic drv_en,
    input logic drv_lvl,
    input logic ref_err_n,
    input logic vco_err_n,
    input logic lock_ok
);
    // R2
    ref_sets_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_edge |=> !ref_err_n);
    // R3
    vco_sets_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vco_edge |=> !vco_err_n);
    // R5
    coincident_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_err_n && !vco_err_n && !ref_edge && !vco_edge) |=> (ref_err_n && vco_err_n));
    // R7
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_err_n != vco_err_n) |=> !lock_ok);
    // R8
    up_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_err_n && vco_err_n && !vco_edge) |=> !ref_err_n);
    // R2
    high_drive_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && drv_lvl) |-> (!ref_err_n && vco_err_n));
    // R9
    float_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> !drv_lvl);
endmodule

bind pfd_tristate pfd_tristate_chk u_chk (.*);

// File: tb/pfd_tristate_tb.sv
`timescale 1ns/1ps
module pfd_tristate_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_edge = 1'b0;
    logic vco_edge = 1'b0;
    logic drv_en, drv_lvl, ref_err_n, vco_err_n, lock_ok;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pfd_tristate u_dut (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .vco_edge(vco_edge),
        .drv_en(drv_en), .drv_lvl(drv_lvl), .ref_err_n(ref_err_n),
        .vco_err_n(vco_err_n), .lock_ok(lock_ok)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive edge masks cycle by cycle and compare every output with the
    // flag behaviour stated in R2/R3/R6/R7/R9. Returns pulse statistics.
    task automatic run_case(input string req, input logic [31:0] rmask,
                            input logic [31:0] vmask, input int n,
                            output int en_cyc, output int both_low,
                            output int lock_low);
        logic eu = 1'b0, ed = 1'b0, pu, pd, clr;
        logic [4:0] exp_v, act_v;
        en_cyc = 0; both_low = 0; lock_low = 0;
        for (int i = 0; i < n; i++) begin
            ref_edge = rmask[i];
            vco_edge = vmask[i];
            @(negedge clk);
            pu = eu; pd = ed; clr = eu & ed;
            eu = clr ? rmask[i] : (eu | rmask[i]);
            ed = clr ? vmask[i] : (ed | vmask[i]);
            exp_v = {eu ^ ed, eu & ~ed, ~eu, ~ed, ~(pu ^ pd)};
            act_v = {drv_en, drv_lvl, ref_err_n, vco_err_n, lock_ok};
            check(act_v == exp_v, req, "outputs {en,lvl,rn,vn,lock} R7 R9",
                  int'(act_v), int'(exp_v));
            if (drv_en) en_cyc++;
            if (!ref_err_n && !vco_err_n) both_low++;
            if (!lock_ok) lock_low++;
        end
        ref_edge = 1'b0;
        vco_edge = 1'b0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ref_edge = i[0];
            vco_edge = 1'b0;
            @(negedge clk);
            check(ref_err_n && vco_err_n && !drv_en && !drv_lvl && !lock_ok, "R1",
                  "reset outputs", int'({drv_en, drv_lvl, ref_err_n, vco_err_n, lock_ok}),
                  int'(5'b00110));
        end
        ref_edge = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(lock_ok == 1'b1, "R7", "lock after reset release", int'(lock_ok), 1);
        check(ref_err_n && vco_err_n, "R1", "flags clear after release",
              int'({ref_err_n, vco_err_n}), 3);
    endtask

    task automatic test_lag();
        int e, b, l;
        run_case("R2", 32'h0000_0002, 32'h0000_0020, 12, e, b, l);
        check(e == 4, "R4", "lag drive width", e, 4);
        check(l == 4, "R7", "lag lock-low cycles", l, 4);
    endtask

    task automatic test_lead();
        int e, b, l;
        run_case("R3", 32'h0000_0200, 32'h0000_0004, 14, e, b, l);
        check(e == 7, "R4", "lead drive width", e, 7);
        check(b == 1, "R3", "lead coincident end", b, 1);
    endtask

    task automatic test_coincident();
        int e, b, l;
        run_case("R5", 32'h0000_0008, 32'h0000_0008, 8, e, b, l);
        check(e == 0, "R5", "coincident drive cycles", e, 0);
        check(b == 1, "R5", "coincident low width", b, 1);
        check(l == 0, "R5", "coincident lock-low cycles", l, 0);
    endtask

    task automatic test_clear_edge();
        int e, b, l;
        run_case("R6", 32'h0000_0012, 32'h0000_0108, 14, e, b, l);
        check(e == 6, "R6", "edge in clearing cycle kept", e, 6);
        check(b == 2, "R6", "two coincident ends", b, 2);
    endtask

    task automatic test_repeat();
        int e, b, l;
        run_case("R8", 32'h0000_000E, 32'h0000_0040, 12, e, b, l);
        check(e == 5, "R8", "repeated ref edges ignored", e, 5);
        check(b == 1, "R8", "single coincident end", b, 1);
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_lag();
        test_lead();
        test_coincident();
        test_clear_edge();
        test_repeat();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule